// File: doc/BRIEF.md
# Two-Group Eight-Channel PWM Generator

This block drives eight pulse-width-modulated outputs from a single base clock. The channels are split into a low group (channels 0 to 3) and a high group (channels 4 to 7). Each group has one prescaler select that divides the base clock by 16, 64, 256 or 512 to form that group's tick. Each group also has an 8-bit period counter that advances once per tick, so one period is always 256 ticks. Each channel compares its duty value against its group's counter. While the PWM enable of a channel is low, the pin mirrors a general-purpose output bit instead.

Each group timer is a two-state machine. In GT_IDLE, none of the group's channels is enabled, and the divider and counter are held at zero. The transition GT_IDLE to GT_RUN fires on the first clock edge at which any channel of the group is enabled. In GT_RUN the divider counts. A change of the group's select restarts the divider and counter while the machine stays in GT_RUN. The transition GT_RUN to GT_IDLE fires when no channel of the group is enabled any more. Duty values pass through a per-channel shadow register. That register reloads when the counter wraps, when the group restarts, and throughout GT_IDLE.

Top module: `pwm8_two_group`

## Requirements
- R1: While `pwm_en[i]` is 0, `pwm_out[i]` equals `gpo_val[i]`, including during and right after reset.
- R2: With select 0, a period lasts 4096 base clocks (256 ticks of 16 clocks), and a channel with duty D is high for exactly 16·D base clocks per period.
- R3: Duty 0 keeps an enabled output low for the whole period; duty 255 keeps it high for 255 of the 256 ticks.
- R4: The 2-bit select encodes the tick length in base clocks as 0→16, 1→64, 2→256, 3→512.
- R5: `psel_lo` times channels 0–3 and `psel_hi` times channels 4–7; the two groups run independently.
- R6: A duty value changed during a period takes effect only from the next period (at the 255→0 wrap).
- R7: A change of a group's select clears that group's divider and counter on the next clock edge, starting a new period at count 0.
- R8: While no channel of a group is enabled, the group's counter is held at 0 (GT_IDLE). Enabling a channel starts a period at count 0 with the duty value present at that moment.
- R9: An enabled output is high while the group count is less than its duty, so a nonzero duty gives a high level in the first tick of each period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| psel_lo | input | 2 | Prescaler select for channels 0–3 |
| psel_hi | input | 2 | Prescaler select for channels 4–7 |
| duty_flat | input | 64 | Duty values, channel i at bits [8i+7:8i] |
| pwm_en | input | 8 | Per-channel PWM enable |
| gpo_val | input | 8 | General-purpose output level used when PWM is disabled |
| pwm_out | output | 8 | Channel outputs |

## Verification
The bench counts high samples over whole periods at the extreme duties 0 and 255. A comparator that is off by one, for example one that uses less-or-equal, would show a count one tick too long at every duty. The bench rewrites a duty in mid-period and expects the old count in that period and the new count in the next; a design without the shadow register would mix the two counts. It changes the select while the counter sits deep in a period, and the resulting high count shows whether the counter restarted. It also runs both groups at different selects at the same time, which exposes any crossed select wiring.

// File: rtl/pwm8_pkg.sv
package pwm8_pkg;
    localparam int PSEL_W = 2;
    localparam int DIV_W  = 9;

    typedef enum logic [0:0] {
        GT_IDLE = 1'b0,
        GT_RUN  = 1'b1
    } grp_state_t;

    // last divider count for each select code: tick length minus one
    function automatic logic [DIV_W-1:0] div_last(input logic [PSEL_W-1:0] sel);
        logic [DIV_W-1:0] v;
        unique case (sel)
            2'd0:    v = DIV_W'(15);
            2'd1:    v = DIV_W'(63);
            2'd2:    v = DIV_W'(255);
            default: v = DIV_W'(511);
        endcase
        return v;
    endfunction
endpackage

// File: rtl/pwm8_group_timer.sv
module pwm8_group_timer
    import pwm8_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PSEL_W-1:0] sel_i,
    input  logic              any_en_i,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              load_o
);
    grp_state_t        state_q, state_d;
    logic [PSEL_W-1:0] sel_q;
    logic [DIV_W-1:0]  div_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              sel_chg, clear, tick;

    assign sel_chg = (sel_i != sel_q);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= GT_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GT_IDLE: if (any_en_i)  state_d = GT_RUN;
            GT_RUN:  if (!any_en_i) state_d = GT_IDLE;
            default: state_d = GT_IDLE;
        endcase
    end

    always_comb begin
        clear  = 1'b0;
        tick   = 1'b0;
        unique case (state_q)
            GT_IDLE: clear = 1'b1;
            GT_RUN: begin
                clear = sel_chg || !any_en_i;
                tick  = !clear && (div_q == div_last(sel_i));
            end
            default: clear = 1'b1;
        endcase
        load_o = clear || (tick && (cnt_q == '1));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
            div_q <= '0;
            cnt_q <= '0;
        end else begin
            sel_q <= sel_i;
            if (clear) begin
                div_q <= '0;
                cnt_q <= '0;
            end else if (tick) begin
                div_q <= '0;
                cnt_q <= cnt_q + 1'b1;
            end else begin
                div_q <= div_q + 1'b1;
            end
        end
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/pwm8_channel.sv
module pwm8_channel #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] duty_i,
    input  logic         load_i,
    input  logic [W-1:0] cnt_i,
    input  logic         en_i,
    input  logic         gpo_i,
    output logic         out_o
);
    logic [W-1:0] shadow_q;

    always_ff @(posedge clk) begin
        if (!rst_n)      shadow_q <= '0;
        else if (load_i) shadow_q <= duty_i;
    end

    assign out_o = en_i ? (cnt_i < shadow_q) : gpo_i;
endmodule

// File: rtl/pwm8_two_group.sv
module pwm8_two_group
    import pwm8_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int DUTY_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [PSEL_W-1:0]        psel_lo,
    input  logic [PSEL_W-1:0]        psel_hi,
    input  logic [NUM_CH*DUTY_W-1:0] duty_flat,
    input  logic [NUM_CH-1:0]        pwm_en,
    input  logic [NUM_CH-1:0]        gpo_val,
    output logic [NUM_CH-1:0]        pwm_out
);
    localparam int NUM_GRP = 2;
    localparam int GRP_CH  = NUM_CH / NUM_GRP;

    logic [NUM_GRP-1:0][DUTY_W-1:0] grp_cnt;
    logic [NUM_GRP-1:0]             grp_load;

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        pwm8_group_timer #(.CNT_W(DUTY_W)) u_tmr (
            .clk      (clk),
            .rst_n    (rst_n),
            .sel_i    ((g == 0) ? psel_lo : psel_hi),
            .any_en_i (|pwm_en[g*GRP_CH +: GRP_CH]),
            .cnt_o    (grp_cnt[g]),
            .load_o   (grp_load[g])
        );
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        pwm8_channel #(.W(DUTY_W)) u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .duty_i (duty_flat[c*DUTY_W +: DUTY_W]),
            .load_i (grp_load[c/GRP_CH]),
            .cnt_i  (grp_cnt[c/GRP_CH]),
            .en_i   (pwm_en[c]),
            .gpo_i  (gpo_val[c]),
            .out_o  (pwm_out[c])
        );
    end
endmodule

// File: rtl/pwm8_two_group_chk.sv
module pwm8_two_group_chk #(
    parameter int NUM_CH = 8,
    parameter int DUTY_W = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [1:0]               psel_lo,
    input logic [1:0]               psel_hi,
    input logic [NUM_CH-1:0]        pwm_en,
    input logic [NUM_CH-1:0]        gpo_val,
    input logic [NUM_CH-1:0]        pwm_out,
    input logic [1:0][DUTY_W-1:0]   grp_cnt
);
    localparam int GRP_CH = NUM_CH / 2;

    AST_GPO_FALLBACK: assert property (@(posedge clk) disable iff (!rst_n)
        ((pwm_out ^ gpo_val) & ~pwm_en) == '0); // R1

    AST_LO_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_cnt[0] != $past(grp_cnt[0])) |->
        ((grp_cnt[0] == DUTY_W'($past(grp_cnt[0]) + 1'b1)) || (grp_cnt[0] == '0))); // R2

    AST_HI_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_cnt[1] != $past(grp_cnt[1])) |->
        ((grp_cnt[1] == DUTY_W'($past(grp_cnt[1]) + 1'b1)) || (grp_cnt[1] == '0))); // R5

    AST_LO_SEL_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (psel_lo != $past(psel_lo)) |=> (grp_cnt[0] == '0)); // R7

    AST_HI_SEL_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (psel_hi != $past(psel_hi)) |=> (grp_cnt[1] == '0)); // R7

    AST_LO_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_en[GRP_CH-1:0] == '0) |=> (grp_cnt[0] == '0)); // R8

    AST_HI_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_en[NUM_CH-1:GRP_CH] == '0) |=> (grp_cnt[1] == '0)); // R8
endmodule

bind pwm8_two_group pwm8_two_group_chk #(.NUM_CH(NUM_CH), .DUTY_W(DUTY_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .psel_lo (psel_lo),
    .psel_hi (psel_hi),
    .pwm_en  (pwm_en),
    .gpo_val (gpo_val),
    .pwm_out (pwm_out),
    .grp_cnt (grp_cnt)
);

// File: tb/sim_pwm8_two_group.sv
module sim_pwm8_two_group;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 5;
    localparam logic [7:0] VEC_DUTY [NVEC] = '{8'd0, 8'd1, 8'd77, 8'd128, 8'd255};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  psel_lo = 2'd0;
    logic [1:0]  psel_hi = 2'd0;
    logic [63:0] duty_flat = '0;
    logic [7:0]  pwm_en = '0;
    logic [7:0]  gpo_val = '0;
    logic [7:0]  pwm_out;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm8_two_group u0 (
        .clk(clk), .rst_n(rst_n), .psel_lo(psel_lo), .psel_hi(psel_hi),
        .duty_flat(duty_flat), .pwm_en(pwm_en), .gpo_val(gpo_val), .pwm_out(pwm_out)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_duty(input int ch, input int val);
        duty_flat[ch*8 +: 8] = 8'(val);
    endtask

    task automatic go_idle();
        @(negedge clk);
        pwm_en = '0;
        repeat (2) @(negedge clk);
    endtask

    task automatic count_two(input int n, input int ca, input int cb,
                             output int ha, output int hb);
        ha = 0; hb = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_out[ca]) ha++;
            if (pwm_out[cb]) hb++;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int ha, hb;
        repeat (3) @(negedge clk);
        chk("R1 reset gpo low", pwm_out, 0);
        gpo_val = 8'hA5;
        @(negedge clk);
        chk("R1 in reset follows gpo", pwm_out, 8'hA5);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 after reset follows gpo", pwm_out, 8'hA5);

        // vector table: channel 0, select 0, one full period each
        for (int v = 0; v < NVEC; v++) begin
            go_idle();
            set_duty(0, VEC_DUTY[v]);
            pwm_en = 8'h01;
            count_two(4096, 0, 7, ha, hb);
            chk($sformatf("R2 R3 duty %0d high clocks", VEC_DUTY[v]), ha, 16 * VEC_DUTY[v]);
            if (v == 1) chk("R1 idle group pin 7 follows gpo", hb, 4096);
        end

        // R4 R5: groups at different selects together
        go_idle();
        psel_hi = 2'd1;
        set_duty(0, 100);
        set_duty(5, 50);
        repeat (2) @(negedge clk);
        pwm_en = 8'h21;
        count_two(16384, 0, 5, ha, hb);
        chk("R5 low group select 0, 4 periods", ha, 4 * 16 * 100);
        chk("R4 R5 high group select 1", hb, 64 * 50);

        // R4 select 2 on high group
        go_idle();
        psel_hi = 2'd2;
        set_duty(5, 3);
        repeat (2) @(negedge clk);
        pwm_en = 8'h20;
        count_two(2048, 5, 0, ha, hb);
        chk("R4 select 2 tick 256", ha, 3 * 256);

        // R4 select 3 on low group, plus R9 first sample high
        go_idle();
        psel_lo = 2'd3;
        set_duty(0, 2);
        repeat (2) @(negedge clk);
        pwm_en = 8'h01;
        @(negedge clk);
        chk("R9 high in first tick", int'(pwm_out[0]), 1);
        count_two(2047, 0, 5, ha, hb);
        chk("R4 select 3 tick 512", ha + 1, 2 * 512);

        // R6 shadow: duty change mid-period
        go_idle();
        psel_lo = 2'd0;
        set_duty(0, 32);
        repeat (2) @(negedge clk);
        pwm_en = 8'h01;
        ha = 0;
        for (int i = 0; i < 4096; i++) begin
            @(negedge clk);
            if (pwm_out[0]) ha++;
            if (i == 1000) set_duty(0, 200);
        end
        chk("R6 old duty holds in current period", ha, 16 * 32);
        count_two(4096, 0, 5, ha, hb);
        chk("R6 new duty from next period", ha, 16 * 200);

        // R7 restart on select change deep in a period
        go_idle();
        set_duty(0, 4);
        repeat (2) @(negedge clk);
        pwm_en = 8'h01;
        repeat (2000) @(negedge clk);
        chk("R7 low before change", int'(pwm_out[0]), 0);
        psel_lo = 2'd1;
        @(negedge clk);
        chk("R7 restart puts count at 0", int'(pwm_out[0]), 1);
        count_two(16383, 0, 5, ha, hb);
        chk("R7 full period after restart", ha + 1, 64 * 4);

        // R8 disable returns pin to gpo and re-enable starts at 0
        go_idle();
        chk("R8 R1 disabled pins follow gpo", pwm_out, 8'hA5);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule